// File: doc/BRIEF.md
# Staircase-Ramp ADC Conversion Controller

This block is the digital half of a counter-type analog-to-digital converter. It drives an N-bit code to an external DAC and watches one comparator bit. The comparator bit is high while the DAC level is still below the held analog input. Each conversion has three phases. First, a sample/hold strobe is pulsed for one clock. Next, the code is held at zero for a programmable settle interval. Finally, the code climbs by one per clock until the comparator reports that the DAC level has reached the input.

The comparator bit is asynchronous, so it passes through a two-stage synchronizer. By the time a trip is seen, the code has already moved on by two steps. To avoid an overshot result, each code emitted during the ramp is carried through a tag pipeline as deep as the synchronizer, together with a valid bit. The code that is latched is the tagged code the comparator was actually judging.

When the code reaches all ones and the comparator never trips, the controller saturates: it stores all ones and raises an over-range flag. Every result update comes with a one-cycle done pulse. The code then returns to zero and, while enable is high, the next conversion starts at once. If enable is dropped, the conversion in flight still finishes. The controller then rests with the DAC code at zero.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the DAC code, strobe, done, result and over-range outputs are all zero.
- R2: A conversion begins with the sample/hold strobe high for exactly one cycle. The code is then zero for the settle count captured in that strobe cycle. It then takes the values 0, 1, 2, … one step per clock, and stops rising at all ones.
- R3: The result equals the first code at which the comparator input is low (DAC level not below the input). This means an input at level v (0..2^N−1) yields result v, with no overshoot from the synchronizer delay.
- R4: The done pulse occurs exactly settle + min(v, 2^N−1) + 4 cycles after the strobe cycle.
- R5: If the comparator is still high for the all-ones code, the result is all ones and over-range is 1. Any result from a comparator trip clears over-range to 0.
- R6: Done is high for one cycle per conversion. Result and over-range keep their values in every cycle without done.
- R7: In the done cycle the DAC code is zero. With enable high, the strobe of the next conversion is high in that same cycle.
- R8: If enable is low at completion, no strobe follows: the DAC code stays zero and the result stays unchanged until enable returns. Enable high while idle gives a strobe on the next cycle.
- R9: With a settle count of zero, the ramp code 0 appears in the cycle right after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable_i | input | 1 | Run conversions continuously while high |
| settle_i | input | SETTLE_W | Settle cycles after the strobe, captured in the strobe cycle |
| cmp_below_i | input | 1 | Asynchronous comparator: 1 = DAC level below held input |
| dac_code_o | output | CODE_W | Code driven to the DAC |
| sh_strobe_o | output | 1 | One-cycle sample/hold strobe |
| result_o | output | CODE_W | Last conversion result |
| done_o | output | 1 | One-cycle pulse on each result update |
| over_range_o | output | 1 | Last result was saturated |

## Verification
The assertions check several properties on every cycle:
- the ramp advances by exactly one while counting;
- the strobe never lasts two cycles;
- done is a single-cycle pulse, and the result is stable outside it;
- a saturated flag always comes with an all-ones result;
- the idle state always drives code zero.

Other behaviours depend on the analog loop, so only the bench scenarios can show them. The bench models the comparator and the sample/hold against the DAC code. These scenarios cover the absence of overshoot through the synchronizer, the exact data-dependent latency, the boundary inputs zero, all ones and beyond full scale, a zero settle count, chained conversions, and the drain-to-idle behaviour when enable drops.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_SETTLE,
        ST_COUNT,
        ST_DRAIN
    } seq_state_e;

endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SETTLE_W = 4,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                cmp_s_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                strobe_o,
    output logic                load_o,
    output logic [CODE_W-1:0]   load_code_o,
    output logic                load_over_o
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
    } tag_t;

    typedef struct packed {
        seq_state_e         st;
        logic [CODE_W-1:0]  code;
        logic [SETTLE_W-1:0] wait_cnt;
        tag_t [STAGES-1:0]  tags;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    tag_t      oldest;
    logic      in_run, hit, sat, load;

    assign oldest = r_q.tags[STAGES-1];
    assign in_run = (r_q.st == ST_COUNT) || (r_q.st == ST_DRAIN);
    assign hit    = in_run && oldest.vld && !cmp_s_i;
    assign sat    = in_run && oldest.vld && cmp_s_i && (oldest.code == CODE_MAX);
    assign load   = hit || sat;

    always_comb begin
        r_d = r_q;
        for (int i = STAGES - 1; i > 0; i--) begin
            r_d.tags[i] = r_q.tags[i-1];
        end
        r_d.tags[0].vld  = (r_q.st == ST_COUNT);
        r_d.tags[0].code = r_q.code;

        case (r_q.st)
            ST_IDLE: begin
                r_d.code = '0;
                if (enable_i) r_d.st = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                r_d.code     = '0;
                r_d.wait_cnt = settle_i;
                r_d.st       = (settle_i == '0) ? ST_COUNT : ST_SETTLE;
            end
            ST_SETTLE: begin
                if (r_q.wait_cnt <= SETTLE_W'(1)) r_d.st = ST_COUNT;
                else r_d.wait_cnt = r_q.wait_cnt - SETTLE_W'(1);
            end
            ST_COUNT: begin
                if (r_q.code == CODE_MAX) r_d.st = ST_DRAIN;
                else r_d.code = r_q.code + CODE_W'(1);
            end
            ST_DRAIN: begin
                r_d.code = r_q.code;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (load) begin
            r_d.code = '0;
            r_d.tags = '0;
            r_d.st   = enable_i ? ST_SAMPLE : ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.code     <= '0;
            r_q.wait_cnt <= '0;
            r_q.tags     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o      = r_q.code;
    assign strobe_o    = (r_q.st == ST_SAMPLE);
    assign load_o      = load;
    assign load_code_o = sat ? CODE_MAX : oldest.code;
    assign load_over_o = sat;

    // R2: ramp rises by one per clock while counting
    p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COUNT && r_q.code != CODE_MAX && !load)
            |=> (r_q.code == $past(r_q.code) + CODE_W'(1)));

    // R2: strobe lasts a single cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R8: idle always drives a zero code
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (r_q.code == '0));

    // R7: code is zero right after a completion
    p_clear_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (r_q.code == '0));

endmodule

// File: rtl/ramp_result.sv
module ramp_result #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              over_i,
    output logic [CODE_W-1:0] result_o,
    output logic              over_o,
    output logic              done_o
);

    typedef struct packed {
        logic [CODE_W-1:0] result;
        logic              over;
        logic              done;
    } res_regs_t;

    res_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = load_i;
        if (load_i) begin
            r_d.result = code_i;
            r_d.over   = over_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result_o = r_q.result;
    assign over_o   = r_q.over;
    assign done_o   = r_q.done;

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: result and flag hold outside done
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(over_o)));

    // R5: saturated flag implies all-ones result
    p_over_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |-> (result_o == '1));

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
    parameter int CODE_W   = 8,
    parameter int SETTLE_W = 4,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                cmp_below_i,
    output logic [CODE_W-1:0]   dac_code_o,
    output logic                sh_strobe_o,
    output logic [CODE_W-1:0]   result_o,
    output logic                done_o,
    output logic                over_range_o
);

    logic              cmp_s;
    logic              load;
    logic [CODE_W-1:0] load_code;
    logic              load_over;

    ramp_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_below_i),
        .q_o   (cmp_s)
    );

    ramp_seq #(
        .CODE_W   (CODE_W),
        .SETTLE_W (SETTLE_W),
        .STAGES   (STAGES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .settle_i    (settle_i),
        .cmp_s_i     (cmp_s),
        .code_o      (dac_code_o),
        .strobe_o    (sh_strobe_o),
        .load_o      (load),
        .load_code_o (load_code),
        .load_over_o (load_over)
    );

    ramp_result #(.CODE_W(CODE_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .code_i   (load_code),
        .over_i   (load_over),
        .result_o (result_o),
        .over_o   (over_range_o),
        .done_o   (done_o)
    );

endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb;

    localparam int CW = 8;
    localparam int SW = 4;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic          cmp_below_i;
    logic [CW-1:0] dac_code_o;
    logic          sh_strobe_o;
    logic [CW-1:0] result_o;
    logic          done_o;
    logic          over_range_o;

    logic [CW:0]   vin_src = '0;
    logic [CW:0]   vin_held = '0;
    int            cyc = 0;
    int            n_cmp = 0;
    int            n_bad = 0;
    int            prev_res = 0;
    int            prev_over = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (sh_strobe_o) vin_held <= vin_src;
    end

    assign cmp_below_i = ({1'b0, dac_code_o} < vin_held);

    ramp_adc_ctrl #(.CODE_W(CW), .SETTLE_W(SW), .STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .settle_i     (settle_i),
        .cmp_below_i  (cmp_below_i),
        .dac_code_o   (dac_code_o),
        .sh_strobe_o  (sh_strobe_o),
        .result_o     (result_o),
        .done_o       (done_o),
        .over_range_o (over_range_o)
    );

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // one conversion: called at a negedge; drives vin/settle, waits for strobe, follows to done
    task automatic conv(input int v, input int settle, input bit drop_en);
        int t0, k, lat, exp_res, exp_over, exp_lat, ramp_bad_act, ramp_bad_exp;
        bit ramp_ok, side_ok;
        vin_src  = (CW+1)'(v);
        settle_i = SW'(settle);
        while (!sh_strobe_o) @(negedge clk);
        t0 = cyc;
        exp_res  = (v > MAXC) ? MAXC : v;
        exp_over = (v > MAXC) ? 1 : 0;
        exp_lat  = settle + exp_res + 4;
        ramp_ok = 1'b1;
        side_ok = 1'b1;
        ramp_bad_act = 0;
        ramp_bad_exp = 0;
        lat = -1;
        forever begin
            @(negedge clk);
            k = cyc - t0;
            if (done_o) begin
                lat = k;
                break;
            end
            if (k > 2000) break;
            if (drop_en && k == 2) enable_i = 1'b0;
            if (sh_strobe_o || done_o || int'(result_o) != prev_res
                || int'(over_range_o) != prev_over) side_ok = 1'b0;
            if (k <= settle) begin
                if (dac_code_o != '0 && ramp_ok) begin
                    ramp_ok = 1'b0; ramp_bad_act = int'(dac_code_o); ramp_bad_exp = 0;
                end
            end else begin
                int e;
                e = (k - settle - 1 > MAXC) ? MAXC : k - settle - 1;
                if (int'(dac_code_o) != e && ramp_ok) begin
                    ramp_ok = 1'b0; ramp_bad_act = int'(dac_code_o); ramp_bad_exp = e;
                end
            end
        end
        chk(ramp_ok, (settle == 0) ? "R9 ramp start" : "R2 settle/ramp code", ramp_bad_act, ramp_bad_exp);
        chk(side_ok, "R6 hold/single strobe/no done during conversion", 0, 0);
        chk(lat == exp_lat, "R4 latency", lat, exp_lat);
        chk(int'(result_o) == exp_res, "R3 result", int'(result_o), exp_res);
        chk(int'(over_range_o) == exp_over, "R5 over-range", int'(over_range_o), exp_over);
        chk(dac_code_o == '0, "R7 code zero at done", int'(dac_code_o), 0);
        chk(sh_strobe_o == enable_i, "R7 restart strobe with done", int'(sh_strobe_o), int'(enable_i));
        prev_res  = int'(result_o);
        prev_over = int'(over_range_o);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(dac_code_o == '0 && !sh_strobe_o && !done_o && result_o == '0 && !over_range_o,
            "R1 outputs in reset", int'(dac_code_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_code_o == '0 && !sh_strobe_o && !done_o && result_o == '0 && !over_range_o,
            "R1 outputs after reset", int'(result_o), 0);
    endtask

    task automatic t_start();
        enable_i = 1'b1;
        @(negedge clk);
        chk(sh_strobe_o == 1'b1, "R8 strobe one cycle after enable", int'(sh_strobe_o), 1);
    endtask

    task automatic t_chain();
        conv(100, 3, 1'b0);
        conv(0, 2, 1'b0);
        conv(MAXC, 1, 1'b0);
        conv(MAXC + 1, 2, 1'b0);
        conv(37, 5, 1'b0);
        conv(1, 0, 1'b0);
        conv(200, 0, 1'b0);
    endtask

    task automatic t_disable();
        bit idle_ok;
        conv(50, 2, 1'b1);
        idle_ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (sh_strobe_o || done_o || dac_code_o != '0 || int'(result_o) != prev_res)
                idle_ok = 1'b0;
        end
        chk(idle_ok, "R8 idle after enable drop", int'(dac_code_o), 0);
        t_start();
        conv(9, 1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_start();
        t_chain();
        t_disable();
        summary_and_end();
    end

endmodule